// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a byte-oriented I2C slave that lets an external host read and write a small bank of 8-bit registers. It oversamples SCL and SDA with a fast system clock and finds START, repeated START and STOP in that clock domain. It answers to one of two 7-bit device addresses, picked by a strap input. SDA is driven through an active-low open-drain enable.

After the device address with the write direction, the first byte the host sends sets a 5-bit register pointer. Each later byte is written at the pointer, and the pointer then steps by one. To read, the host writes the pointer, issues a repeated START and sends the address with the read direction. The slave then returns bytes from the pointer onward, stepping after each byte. The register file sits behind a plain parallel port: address, write data, one-cycle write strobe and combinational read data. Only the lowest `IMPL_REGS` addresses are backed by registers. Reads above that range return zero, and writes there are dropped.

Top module: `i2c_reg_slave`

## Requirements
- R1: The device address is 7'b0101001 while `addr_strap` is 0 and 7'b1010110 while it is 1. A matching address byte is acknowledged by SDA held low through the ninth SCL clock.
- R2: An address byte that does not match gets no acknowledge and causes no register write. The slave ignores the rest of the transfer until the next START, and the register pointer keeps its value.
- R3: In a write transfer, the first byte after the address sets the pointer to the byte's low 5 bits. The upper three bits are ignored, and this byte causes no register write.
- R4: Each later byte in a write transfer is acknowledged and gives exactly one `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments by one.
- R5: After a repeated START and the address with the read bit (bit 0 = 1), the slave returns bytes MSB first, starting at the stored pointer. The pointer increments after each byte.
- R6: When the host does not acknowledge a read byte, the slave stops driving SDA and drives nothing more until the next START.
- R7: The pointer wraps from 31 to 0.
- R8: At pointer values of `IMPL_REGS` (24) and above, reads return 8'h00 and writes produce no `reg_we` pulse.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP the slave releases SDA and waits for a START.
- R10: `sda_drive_low` changes only while the synchronised SCL is low.
- R11: After reset, `sda_drive_low` and `reg_we` are 0 and the pointer (`reg_addr`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 1 | Selects which of the two device addresses is used |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 5 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register file contents at `reg_addr` |

## Verification
Directed transfers cover the cases that tell behaviours apart:
- Both strap settings are tried, each against both addresses, which separates a correct match from a reversed one.
- A pointer byte with its upper bits set shows whether those bits are discarded.
- A read starting at 31 shows the wrap and the return of zero above the implemented range together.
- A mismatched transfer carrying data, followed by a read with no pointer write, shows whether a foreign address disturbs the pointer or the registers.

Seeded random bursts of writes and reads at random pointers and lengths are then compared with a bench model. These bursts expose off-by-one errors in the post-increment, in the order of the bits within a byte and in the point where the slave lets go of SDA after a read NACK.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] ADDR_LOW  = 7'b0101001,
  parameter logic [6:0] ADDR_HIGH = 7'b1010110,
  parameter int         PTR_W     = 5,
  parameter int         IMPL_REGS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strap,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_drive_low,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);

  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(IMPL_REGS);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_t;

  state_t           state;
  logic [2:0]       scl_q, sda_q;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg, tx;
  logic [PTR_W-1:0] ptr;
  logic             first_byte, ptr_loaded, rd_mode, master_nack;
  logic             oe, we_q;
  logic [7:0]       wdata_q;

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  wire [6:0] my_addr  = addr_strap ? ADDR_HIGH : ADDR_LOW;
  wire       in_range = {1'b0, ptr} < LIMIT;
  wire [7:0] rd_byte  = in_range ? reg_rdata : 8'h00;

  assign sda_drive_low = oe;
  assign reg_addr      = ptr;
  assign reg_wdata     = wdata_q;
  assign reg_we        = we_q & in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      tx          <= '0;
      ptr         <= '0;
      first_byte  <= 1'b0;
      ptr_loaded  <= 1'b0;
      rd_mode     <= 1'b0;
      master_nack <= 1'b0;
      oe          <= 1'b0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr <= ptr + 1'b1;
      if (start_det) begin
        state      <= S_RX;
        bit_cnt    <= '0;
        first_byte <= 1'b1;
        ptr_loaded <= 1'b0;
        oe         <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE;
        oe    <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_q[1]};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              first_byte <= 1'b0;
              if (first_byte) begin
                if (shreg[7:1] == my_addr) begin
                  rd_mode <= shreg[0];
                  oe      <= 1'b1;
                  state   <= S_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (!ptr_loaded) begin
                ptr        <= shreg[PTR_W-1:0];
                ptr_loaded <= 1'b1;
                oe         <= 1'b1;
                state      <= S_ACK;
              end else begin
                we_q    <= 1'b1;
                wdata_q <= shreg;
                oe      <= 1'b1;
                state   <= S_ACK;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                tx    <= rd_byte;
                oe    <= ~rd_byte[7];
                ptr   <= ptr + 1'b1;
                state <= S_TX;
              end else begin
                oe    <= 1'b0;
                state <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                oe    <= 1'b0;
                state <= S_MACK;
              end else begin
                tx      <= {tx[6:0], 1'b0};
                oe      <= ~tx[6];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              master_nack <= sda_q[1];
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (master_nack) begin
                state <= S_IDLE;
              end else begin
                tx    <= rd_byte;
                oe    <= ~rd_byte[7];
                ptr   <= ptr + 1'b1;
                state <= S_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> reg_addr == PTR_W'($past(reg_addr) + 1'b1));

  a_r10_oe_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_q[2]);

  a_r2_mismatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RX && first_byte && scl_fall && bit_cnt == 4'd8 && shreg[7:1] != my_addr)
      |=> (!sda_drive_low && reg_addr == $past(reg_addr)));

endmodule

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;
  localparam int IMPL = 24;
  localparam logic [6:0] DEV_A = 7'b0101001;
  localparam logic [6:0] DEV_B = 7'b1010110;

  logic clk = 0, rst_n = 0, strap = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, reg_we;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, bad_we = 0, oe_viol = 0, we_count = 0;
  int mp = 0;
  bit done = 0;
  logic [7:0] regs [32];
  logic [7:0] expm [32];
  logic [7:0] wbuf [8];
  logic prev_oe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_drive_low(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
      if (reg_addr >= 5'(IMPL)) bad_we <= bad_we + 1;
    end
    if (scl_m && sda_oe != prev_oe) oe_viol <= oe_viol + 1;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] exp_read(int p);
    return (p < IMPL) ? expm[p] : 8'h00;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; q(); ack = ~sda_line; q(); scl_m = 0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1; q(); b[i] = sda_line; q(); scl_m = 0;
    end
    q(); sda_m = give_ack ? 1'b0 : 1'b1; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] pb, input int n);
    bit ack;
    i2c_start();
    send_byte({dev, 1'b0}, ack); check("R1 address ack", ack, 1);
    send_byte(pb, ack);          check("R3 pointer ack", ack, 1);
    mp = pb[4:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);   check("R4 data ack", ack, 1);
      if (mp < IMPL) expm[mp] = wbuf[i];
      mp = (mp + 1) % 32;
    end
    i2c_stop();
    check("R9 released after stop", sda_oe, 0);
  endtask

  task automatic do_read(input logic [6:0] dev, input bit set_ptr, input logic [7:0] pb, input int n);
    bit ack;
    logic [7:0] b;
    i2c_start();
    if (set_ptr) begin
      send_byte({dev, 1'b0}, ack); check("R1 address ack", ack, 1);
      send_byte(pb, ack);          check("R3 pointer ack", ack, 1);
      mp = pb[4:0];
      i2c_start();
    end
    send_byte({dev, 1'b1}, ack);   check("R5 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check((mp >= IMPL) ? "R8 unimplemented reads zero" : "R5 read data", b, exp_read(mp));
      mp = (mp + 1) % 32;
    end
    q();
    check("R6 released after nack", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    bit ack;
    int wc;
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) begin
      regs[i] = 8'(i * 37 + 11);
      expm[i] = regs[i];
    end
    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 drive after reset", sda_oe, 0);
    check("R11 strobe after reset", reg_we, 0);
    check("R11 pointer after reset", reg_addr, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 + R4: strap low, three writes from 3
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
    wc = we_count;
    do_write(DEV_A, 8'h03, 3);
    check("R4 strobe count", we_count - wc, 3);
    do_read(DEV_A, 1, 8'h03, 3);

    // R2: mismatch leaves pointer and registers alone
    i2c_start();
    send_byte({DEV_B, 1'b0}, ack); check("R2 no ack on mismatch", ack, 0);
    wc = we_count;
    send_byte(8'h01, ack);
    send_byte(8'h77, ack); check("R2 ignored data not acked", ack, 0);
    i2c_stop();
    check("R2 no strobe on mismatch", we_count - wc, 0);
    check("R2 pointer kept", reg_addr, mp);
    do_read(DEV_A, 0, 8'h00, 2);

    // R1: strap high
    strap = 1;
    i2c_start();
    send_byte({DEV_A, 1'b0}, ack); check("R1 low address rejected when strap high", ack, 0);
    i2c_stop();
    wbuf[0] = 8'h5A;
    do_write(DEV_B, 8'h0A, 1);
    do_read(DEV_B, 1, 8'h0A, 1);

    // R3: upper pointer bits ignored
    wbuf[0] = 8'h96;
    do_write(DEV_B, 8'hE2, 1);
    do_read(DEV_B, 1, 8'h02, 1);

    // R7 + R8: wrap past 31 and unimplemented write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wc = we_count;
    do_write(DEV_B, 8'h1F, 2);
    check("R8 write above range dropped", we_count - wc, 1);
    do_read(DEV_B, 1, 8'h1F, 2);
    check("R7 pointer wrapped", reg_addr, 1);

    // random bursts
    strap = 0;
    for (int t = 0; t < 14; t++) begin
      int n = 1 + ($urandom % 4);
      logic [7:0] p = 8'($urandom);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      if ($urandom % 2) do_write(DEV_A, p, n);
      else do_read(DEV_A, 1, p, n);
    end

    check("R8 no strobe above range", bad_we, 0);
    check("R10 drive changes only with SCL low", oe_viol, 0);
    done = 1;
    report();
  end
endmodule